// File: doc/BRIEF.md
# Pipelined Eight-Point Cosine Transform with Rotation Stages

This block computes a one-dimensional discrete cosine transform over eight signed samples. A full vector arrives on one clock edge and the eight coefficients leave together a fixed number of cycles later. A new vector can be accepted on every clock. The block contains no multipliers. Mirrored input pairs first pass through a sum/difference butterfly, and the sums go through a second butterfly. Each pair of coefficients that share one angle as cosine and sine is then produced by one shift-and-add rotator with a hard-wired angle. Six such rotators and a final add/subtract layer complete the transform.

The rotators do not remove their own growth, so every coefficient carries the fixed rotator gain K. The DC term carries an extra factor of 1/sqrt(2), which is the same relative weight the orthonormal transform gives it. A downstream quantiser folds these constant factors into its own step sizes. A valid flag travels alongside the data, and reset clears the flag pipeline.

Top module: `dct8_cordic`

## Requirements
- R1: A vector that is captured with `in_valid` high on clock edge n raises `out_valid` for exactly one cycle, after edge n+14. The latency is 15 cycles.
- R2: The front end forms x[i]+x[7-i] and x[i]-x[7-i] for i=0..3, and then forms the sums and differences of those sums. Because of this, an input with x[i]=x[7-i] gives odd coefficients within tolerance of zero, and an input with x[i]=-x[7-i] gives even coefficients within tolerance of zero.
- R3: For k=1..7, out_y[k] equals K·Σn x[n]·cos((2n+1)kπ/16). out_y[0] equals K·Σn x[n]/sqrt(2). K = Π(i=0..11) sqrt(1+2^(-2i)) ≈ 1.64676. Each result is within ±5 LSB.
- R4: Vectors presented on consecutive cycles each produce their own correct result, on consecutive cycles and in input order.
- R5: `out_valid` is low during reset and after reset until a vector has passed through. Exactly one result appears per accepted vector, and idle input cycles produce no result.
- R6: A constant input of value v gives out_y[0] = K·8v/sqrt(2) and gives out_y[1..7] within tolerance of zero. This holds at both v=255 and v=-256.
- R7: Full-scale inputs, including alternating +255/-256 and half-and-half patterns, give results within the R3 tolerance with no wrap-around.
- R8: Asserting reset discards every vector still in flight. No result appears for those vectors, and the block resumes normally after reset is released.
- R9: Sample n is taken from in_x[n*9 +: 9], two's complement. Coefficient k is driven on out_y[k*14 +: 14], two's complement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the valid pipeline |
| in_valid | input | 1 | Marks in_x as a vector to transform |
| in_x | input | 72 | Eight 9-bit signed samples, sample n at bits n*9 |
| out_valid | output | 1 | Marks out_y as a finished coefficient vector |
| out_y | output | 112 | Eight 14-bit signed coefficients, coefficient k at bits k*14 |

## Verification
The bench drives mirrored-symmetric and mirrored-antisymmetric vectors. A swapped or mis-signed butterfly leg would leak energy into the coefficient half that should be near zero. Constant and full-scale alternating vectors drive the largest magnitudes, so a rotator that is too narrow or an output combine that wraps shows up as a value thousands of LSB off. Random vectors applied back to back catch a mismatched angle or a wrong rotator-to-coefficient pairing. A reset in the middle of a stream catches a valid pipeline that still lets stale results out, and it also catches an off-by-one latency.

// File: rtl/dct8_cordic.sv
module dct8_cordic #(
  parameter int IW = 9,
  parameter int STAGES = 12,
  parameter int GB = 6,
  localparam int OW = IW + 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [8*IW-1:0] in_x,
  output logic            out_valid,
  output logic [8*OW-1:0] out_y
);

  localparam int RW  = OW + GB;
  localparam int LAT = STAGES + 3;
  localparam int CW  = $clog2(LAT + 1) + 1;

  function automatic longint atan_q30(int i);
    case (i)
      0: return 64'sd843314857;
      1: return 64'sd497837829;
      2: return 64'sd263043837;
      3: return 64'sd133525159;
      4: return 64'sd67021687;
      5: return 64'sd33543516;
      6: return 64'sd16775851;
      7: return 64'sd8388437;
      8: return 64'sd4194283;
      9: return 64'sd2097149;
      default: return 64'sd1073741824 >>> i;
    endcase
  endfunction

  function automatic logic [STAGES-1:0] steer(longint ang);
    logic [STAGES-1:0] d;
    longint z;
    z = ang;
    d = '0;
    for (int i = 0; i < STAGES; i++) begin
      d[i] = (z >= 0);
      if (d[i]) z = z - atan_q30(i);
      else      z = z + atan_q30(i);
    end
    return d;
  endfunction

  localparam logic [STAGES-1:0] D_QTR  = steer(64'sd843314857);
  localparam logic [STAGES-1:0] D_8TH  = steer(64'sd421657428);
  localparam logic [STAGES-1:0] D_16TH = steer(64'sd210828714);
  localparam logic [STAGES-1:0] D_3_16 = steer(64'sd632486143);
  localparam logic [5:0][STAGES-1:0] ROT_DIR = {D_16TH, D_3_16, D_3_16, D_16TH, D_8TH, D_QTR};

  logic signed [IW-1:0] x [8];
  for (genvar n = 0; n < 8; n++) begin : g_unpack
    assign x[n] = in_x[n*IW +: IW];
  end

  logic signed [IW:0]   p1_s [4];
  logic signed [IW:0]   p1_d [4];
  logic signed [IW:0]   p2_d [4];
  logic signed [IW+1:0] p2_e [4];

  always_ff @(posedge clk) begin
    for (int i = 0; i < 4; i++) begin
      p1_s[i] <= (IW+1)'(x[i]) + (IW+1)'(x[7-i]);
      p1_d[i] <= (IW+1)'(x[i]) - (IW+1)'(x[7-i]);
      p2_d[i] <= p1_d[i];
    end
    p2_e[0] <= (IW+2)'(p1_s[0]) + (IW+2)'(p1_s[3]);
    p2_e[1] <= (IW+2)'(p1_s[1]) + (IW+2)'(p1_s[2]);
    p2_e[2] <= (IW+2)'(p1_s[0]) - (IW+2)'(p1_s[3]);
    p2_e[3] <= (IW+2)'(p1_s[1]) - (IW+2)'(p1_s[2]);
  end

  logic signed [RW-1:0] rin_x [6];
  logic signed [RW-1:0] rin_y [6];
  assign rin_x[0] = RW'(p2_e[0]) <<< GB;
  assign rin_y[0] = RW'(p2_e[1]) <<< GB;
  assign rin_x[1] = RW'(p2_e[2]) <<< GB;
  assign rin_y[1] = -(RW'(p2_e[3]) <<< GB);
  assign rin_x[2] = RW'(p2_d[0]) <<< GB;
  assign rin_y[2] = -(RW'(p2_d[3]) <<< GB);
  assign rin_x[3] = RW'(p2_d[0]) <<< GB;
  assign rin_y[3] = RW'(p2_d[3]) <<< GB;
  assign rin_x[4] = RW'(p2_d[1]) <<< GB;
  assign rin_y[4] = -(RW'(p2_d[2]) <<< GB);
  assign rin_x[5] = RW'(p2_d[1]) <<< GB;
  assign rin_y[5] = RW'(p2_d[2]) <<< GB;

  logic signed [OW-1:0] tx [6];
  logic signed [OW-1:0] ty [6];

  for (genvar r = 0; r < 6; r++) begin : g_rot
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      logic signed [RW-1:0] ax, ay, qx, qy;
      if (i == 0) begin : g_head
        assign ax = rin_x[r];
        assign ay = rin_y[r];
      end else begin : g_chain
        assign ax = g_stage[i-1].qx;
        assign ay = g_stage[i-1].qy;
      end
      always_ff @(posedge clk) begin
        if (ROT_DIR[r][i]) begin
          qx <= ax - (ay >>> i);
          qy <= ay + (ax >>> i);
        end else begin
          qx <= ax + (ay >>> i);
          qy <= ay - (ax >>> i);
        end
      end
    end
    assign tx[r] = g_stage[STAGES-1].qx[RW-1:GB];
    assign ty[r] = g_stage[STAGES-1].qy[RW-1:GB];
  end

  logic signed [OW-1:0] y [8];
  assign y[0] = ty[0];
  assign y[4] = tx[0];
  assign y[2] = tx[1];
  assign y[6] = ty[1];
  assign y[1] = tx[2] + tx[4];
  assign y[7] = ty[2] - ty[4];
  assign y[3] = tx[3] - ty[5];
  assign y[5] = ty[3] - tx[5];

  always_ff @(posedge clk) begin
    for (int k = 0; k < 8; k++) out_y[k*OW +: OW] <= y[k];
  end

  logic [LAT-1:0] vpipe;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vpipe <= '0;
    else        vpipe <= {vpipe[LAT-2:0], in_valid};
  end
  assign out_valid = vpipe[LAT-1];

  logic signed [IW+2:0] xsum, xdiff;
  always_comb begin
    xsum  = '0;
    xdiff = '0;
    for (int i = 0; i < 4; i++) begin
      xsum  = xsum  + (IW+3)'(x[i]) + (IW+3)'(x[7-i]);
      xdiff = xdiff + (IW+3)'(x[i]) - (IW+3)'(x[7-i]);
    end
  end

  logic [CW-1:0] flight;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flight <= '0;
    else        flight <= flight + CW'(in_valid) - CW'(out_valid);
  end

  // R2
  bfly_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((IW+3)'(p2_e[0]) + (IW+3)'(p2_e[1])) == $past(xsum, 2));

  // R2
  bfly_diff_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((IW+3)'(p1_d[0]) + (IW+3)'(p1_d[1]) + (IW+3)'(p1_d[2]) + (IW+3)'(p1_d[3])) == $past(xdiff));

  // R5
  flight_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flight <= CW'(LAT));

  // R5
  no_orphan_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (flight != '0));

endmodule

// File: tb/dct8_cordic_tb_top.sv
`timescale 1ns/1ps
module dct8_cordic_tb_top;
  localparam int IW  = 9;
  localparam int OW  = 14;
  localparam int LAT = 15;
  localparam real TOL = 5.0;
  localparam real PI  = 3.14159265358979;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [8*IW-1:0] in_x = '0;
  logic out_valid;
  logic [8*OW-1:0] out_y;

  int checks = 0;
  int errors = 0;
  longint cyc = 0;
  real gain;

  real    q_exp[$];
  longint q_stamp[$];
  string  q_tag[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dct8_cordic dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_x(in_x),
    .out_valid(out_valid), .out_y(out_y)
  );

  task automatic send(input int v[8], input string tag);
    real acc;
    @(negedge clk);
    in_valid = 1'b1;
    for (int n = 0; n < 8; n++) in_x[n*IW +: IW] = v[n][IW-1:0];
    for (int k = 0; k < 8; k++) begin
      acc = 0.0;
      for (int n = 0; n < 8; n++) acc += real'(v[n]) * $cos(real'((2*n+1)*k) * PI / 16.0);
      if (k == 0) acc = acc / $sqrt(2.0);
      q_exp.push_back(gain * acc);
    end
    q_stamp.push_back(cyc);
    q_tag.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  task automatic expect_quiet(input string tag);
    checks++;
    if (out_valid !== 1'b0) begin
      errors++;
      $display("FAIL %s out_valid actual %b expected 0", tag, out_valid);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (q_stamp.size() == 0) begin
        checks++; errors++;
        $display("FAIL R5/R8 result with no pending vector actual out_valid=1 expected 0");
      end else begin
        longint st;
        string tg;
        real ex, diff;
        int act;
        bit bad;
        st = q_stamp.pop_front();
        tg = q_tag.pop_front();
        checks++;
        if (cyc - st != LAT) begin
          errors++;
          $display("FAIL R1 latency actual %0d expected %0d (%s)", cyc - st, LAT, tg);
        end
        checks++;
        bad = 1'b0;
        for (int k = 0; k < 8; k++) begin
          ex = q_exp.pop_front();
          act = int'($signed(out_y[k*OW +: OW]));
          diff = real'(act) - ex;
          if (diff > TOL || diff < -TOL) begin
            bad = 1'b1;
            $display("FAIL %s coeff %0d actual %0d expected %0.2f", tg, k, act, ex);
          end
        end
        if (bad) errors++;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual running expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int v[8];
    gain = 1.0;
    for (int i = 0; i < 12; i++) gain = gain * $sqrt(1.0 + 1.0 / real'(1 << (2*i)));

    repeat (5) @(posedge clk);
    @(negedge clk);
    expect_quiet("R5 during reset");
    rst_n = 1'b1;
    idle(3);
    expect_quiet("R5 after reset");

    v = '{100, 0, 0, 0, 0, 0, 0, 0};              send(v, "R3 impulse first");
    v = '{0, 0, 0, 0, 0, 0, 0, -100};             send(v, "R3 impulse last");
    v = '{-7, 3, 12, 25, 41, 60, 82, 107};        send(v, "R3 ramp");
    v = '{255, 255, 255, 255, 255, 255, 255, 255}; send(v, "R6 dc positive");
    v = '{-256, -256, -256, -256, -256, -256, -256, -256}; send(v, "R6 dc negative");
    v = '{255, -256, 255, -256, 255, -256, 255, -256}; send(v, "R7 alternating");
    v = '{-256, 255, -256, 255, -256, 255, -256, 255}; send(v, "R7 alternating inverted");
    v = '{255, 255, 255, 255, -256, -256, -256, -256}; send(v, "R7 half split");
    v = '{255, -256, -256, 255, 255, -256, -256, 255}; send(v, "R7 mirrored extreme");
    v = '{10, -40, 77, 120, 120, 77, -40, 10};    send(v, "R2 symmetric");
    v = '{50, -20, 90, -130, 130, -90, 20, -50};  send(v, "R2 antisymmetric");
    v = '{1, 0, 0, 0, 0, 0, 0, 0};                send(v, "R9 lane order sample0");
    v = '{0, 0, 0, 200, 0, 0, 0, 0};              send(v, "R9 lane order sample3");

    for (int t = 0; t < 40; t++) begin
      for (int n = 0; n < 8; n++) v[n] = int'($urandom_range(511)) - 256;
      send(v, "R4 back-to-back random");
    end

    v = '{30, 60, -90, 120, -150, 180, -210, 240}; send(v, "R5 bubble a");
    idle(3);
    v = '{-30, 5, 44, -81, 99, 12, -60, 7};       send(v, "R5 bubble b");
    idle(1);
    v = '{128, -128, 64, -64, 32, -32, 16, -16};  send(v, "R5 bubble c");
    idle(LAT + 6);
    expect_quiet("R5 idle after drain");
    checks++;
    if (q_stamp.size() != 0) begin
      errors++;
      $display("FAIL R5 results missing actual %0d pending expected 0", q_stamp.size());
    end

    for (int t = 0; t < 3; t++) begin
      for (int n = 0; n < 8; n++) v[n] = 17 * (n + t) - 60;
      send(v, "R8 should be discarded");
    end
    @(negedge clk);
    in_valid = 1'b0;
    rst_n = 1'b0;
    q_exp.delete();
    q_stamp.delete();
    q_tag.delete();
    repeat (3) @(negedge clk);
    expect_quiet("R8 during mid-stream reset");
    rst_n = 1'b1;
    idle(LAT + 6);
    expect_quiet("R8 no stale result");
    v = '{-100, 90, -80, 70, -60, 50, -40, 30};   send(v, "R8 after reset");
    idle(LAT + 6);
    checks++;
    if (q_stamp.size() != 0) begin
      errors++;
      $display("FAIL R8 result after reset missing actual %0d pending expected 0", q_stamp.size());
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule